// File: doc/BRIEF.md
# Serial Receiver Status Flags

This block keeps the receive-side status of an asynchronous serial port. A receive shifter hands it each finished character as a one-cycle strobe with the character's value. The block then holds that value in its receive data register and raises a "data full" flag. It also watches the sampled serial input on each bit-rate enable and raises a "line idle" flag once the line has stayed high for a full character time. That time is ten bit times for 8-bit characters and eleven for 9-bit characters.

Software reaches both flags and the data register through a small register port with two addresses: a status word and the data register. Each flag is cleared by its own two-step sequence. The full flag needs a status read that saw it set, followed by a read of the data register. The idle flag needs a status read that saw it set, followed by a write to the data register. Two conditions hold the idle flag down. Once it has been cleared, it stays low until another character has arrived. It also stays low for as long as the receiver-wakeup control is asserted. The other status bits belong to logic outside this block and always read as zero here.

Top module: `uart_rx_status`

## Requirements
- R1: A `frame_done` pulse loads `frame_data` into the data register and sets the full flag at the next clock edge.
- R2: The full flag clears only on a data-register read (`reg_addr`=1) whose most recent preceding status read (`reg_addr`=0) saw full=1. A data read without such a status read leaves the flag set.
- R3: A character that arrives after the arming status read cancels that arming, so a later data read leaves full set. A character arriving in the same cycle as the clearing data read also leaves full set.
- R4: The idle flag sets on the bit enable that samples the 10th consecutive high input when `mode9`=0, or the 11th when `mode9`=1. Cycles without `bit_tick` are not counted.
- R5: A sampled low restarts the run of highs. The run count saturates at the threshold, so a single idle period sets the flag at most once.
- R6: The idle flag clears only on a data-register write whose most recent preceding status read saw idle=1. A data read, or a write without such a status read, leaves it set.
- R7: The idle flag can set from reset onward. After it is cleared, it cannot set again until a `frame_done` has occurred.
- R8: While `rx_wakeup`=1, an idle run never sets the idle flag. A later idle run with `rx_wakeup`=0 sets it if idle detection is still armed.
- R9: The status word is 8 bits: full at bit 5, idle at bit 4, and bits 7, 6 and 3..0 are 0. `rd_data` shows the status word when `reg_addr`=0 and the data register when `reg_addr`=1. After reset both flags and the data register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe: a character has been received |
| frame_data | input | DATA_W | Received character value |
| bit_tick | input | 1 | Bit-rate enable for sampling `rx_in` |
| rx_in | input | 1 | Sampled serial input level |
| mode9 | input | 1 | 1 selects 9-bit characters (11-bit idle threshold) |
| rx_wakeup | input | 1 | Receiver-wakeup control; suppresses idle flag setting |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = status word, 1 = data register |
| rd_data | output | max(8,DATA_W) | Read data for the selected register |

## Verification
The hardest state to reach is the re-arming of idle detection. Getting there needs a line that has already gone idle, a completed clear sequence, and then a second idle run, both with and without a character in between. The directed tasks build this from whole runs of bit enables. A single low sample opens each run, so the saturated counter restarts. The tasks then count enables up to one short of the threshold and to the threshold itself, so the flag is seen to rise on exactly the expected enable. The cancelled full-flag clear is built the same way, by placing a character strobe between the status read and the data read, or in the same cycle as the data read.

// File: rtl/rxs_pkg.sv
// Package: shared register encodings and status word layout for the
// receiver status block. Assumes an 8-bit status word.
package rxs_pkg;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_DATA   = 1'b1
    } rxs_reg_e;

    localparam int STAT_W   = 8;
    localparam int FULL_POS = 5;
    localparam int IDLE_POS = 4;

    // Build the status word; bits outside the two flags read as zero.
    function automatic logic [STAT_W-1:0] pack_status(input logic full, input logic idle);
        logic [STAT_W-1:0] w;
        w           = '0;
        w[FULL_POS] = full;
        w[IDLE_POS] = idle;
        return w;
    endfunction

endpackage

// File: rtl/rxs_idle_counter.sv
// Module: counts consecutive high samples of the serial input on bit
// enables and emits a one-cycle hit when the run reaches the threshold
// for the selected character length. The count restarts on a low sample
// and saturates at the threshold. Assumes mode9 is stable during a run.
module rxs_idle_counter #(
    parameter int BITS_SHORT = 10,
    parameter int BITS_LONG  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_in,
    input  logic mode9,
    output logic hit_o
);
    localparam int MAX_BITS = (BITS_LONG > BITS_SHORT) ? BITS_LONG : BITS_SHORT;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] limit;

    // Select the threshold for the current character length.
    always_comb begin
        limit = mode9 ? CNT_W'(BITS_LONG) : CNT_W'(BITS_SHORT);
    end

    // Pulse when this enable completes a full run of highs.
    always_comb begin
        hit_o = bit_tick && rx_in && (run_q == limit - CNT_W'(1));
    end

    // Track the run length: restart on low, saturate at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_tick) begin
            if (!rx_in) begin
                run_q <= '0;
            end else if (run_q < limit) begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/rxs_clear_seq.sv
// Module: two-step clear sequencer. A status read arms it when the
// watched flag is set; the following consuming access then produces a
// clear pulse. A status read that sees the flag low, a consuming access,
// or a cancel event disarms it. Assumes a status read and a consuming
// access never happen in the same cycle.
module rxs_clear_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic status_rd_i,
    input  logic consume_i,
    input  logic cancel_i,
    output logic clear_o
);
    logic armed_q;

    // Remember whether the latest status read observed the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (cancel_i) begin
            armed_q <= 1'b0;
        end else if (status_rd_i) begin
            armed_q <= flag_i;
        end else if (consume_i) begin
            armed_q <= 1'b0;
        end
    end

    // Emit the clear when the consuming access follows an arming read.
    always_comb begin
        clear_o = consume_i && armed_q;
    end

endmodule

// File: rtl/uart_rx_status.sv
// Module: receive status flags for an asynchronous serial port. Holds the
// receive data register, the full flag and the line-idle flag, and
// exposes them through a two-address register port. Assumes frame_done is
// a single-cycle strobe and that only one of reg_rd/reg_wr is high.
module uart_rx_status #(
    parameter int DATA_W     = 8,
    parameter int BITS_SHORT = 10,
    parameter int BITS_LONG  = 11,
    localparam int RD_W      = (DATA_W > rxs_pkg::STAT_W) ? DATA_W : rxs_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] frame_data,
    input  logic              bit_tick,
    input  logic              rx_in,
    input  logic              mode9,
    input  logic              rx_wakeup,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic              reg_addr,
    output logic [RD_W-1:0]   rd_data
);
    import rxs_pkg::*;

    logic [DATA_W-1:0] data_q;
    logic              full_q;
    logic              idle_q;
    logic              idle_arm_q;
    logic              stat_rd;
    logic              data_rd;
    logic              data_wr;
    logic              full_clr;
    logic              idle_clr;
    logic              idle_hit;

    // Decode register accesses by address.
    always_comb begin
        stat_rd = reg_rd && (reg_addr == REG_STATUS);
        data_rd = reg_rd && (reg_addr == REG_DATA);
        data_wr = reg_wr && (reg_addr == REG_DATA);
    end

    rxs_idle_counter #(
        .BITS_SHORT (BITS_SHORT),
        .BITS_LONG  (BITS_LONG)
    ) u_idle_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rx_in    (rx_in),
        .mode9    (mode9),
        .hit_o    (idle_hit)
    );

    rxs_clear_seq u_full_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_i      (full_q),
        .status_rd_i (stat_rd),
        .consume_i   (data_rd),
        .cancel_i    (frame_done),
        .clear_o     (full_clr)
    );

    rxs_clear_seq u_idle_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_i      (idle_q),
        .status_rd_i (stat_rd),
        .consume_i   (data_wr),
        .cancel_i    (1'b0),
        .clear_o     (idle_clr)
    );

    // Capture each received character into the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (frame_done) begin
            data_q <= frame_data;
        end
    end

    // Full flag: a new character wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (frame_done) begin
            full_q <= 1'b1;
        end else if (full_clr) begin
            full_q <= 1'b0;
        end
    end

    // Idle arming: set from reset and by each character, dropped on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_arm_q <= 1'b1;
        end else if (frame_done) begin
            idle_arm_q <= 1'b1;
        end else if (idle_clr) begin
            idle_arm_q <= 1'b0;
        end
    end

    // Idle flag: set on an armed, unsuppressed hit; clear on the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= 1'b0;
        end else if (idle_hit && idle_arm_q && !rx_wakeup) begin
            idle_q <= 1'b1;
        end else if (idle_clr) begin
            idle_q <= 1'b0;
        end
    end

    // Read mux for the two addresses.
    always_comb begin
        if (reg_addr == REG_DATA) begin
            rd_data = RD_W'(data_q);
        end else begin
            rd_data = RD_W'(pack_status(full_q, idle_q));
        end
    end

endmodule

// File: rtl/uart_rx_status_chk.sv
// Module: property checker for uart_rx_status, attached with bind.
// Assumes the same access rules as the block it watches.
module uart_rx_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_done,
    input logic [DATA_W-1:0] frame_data,
    input logic [DATA_W-1:0] data_q,
    input logic              full_q,
    input logic              idle_q,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic              reg_addr,
    input logic              rx_wakeup,
    input logic              bit_tick,
    input logic              rx_in
);

    assert_frame_sets_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> full_q);

    assert_frame_loads_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (data_q == $past(frame_data)));

    assert_full_falls_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(reg_rd && reg_addr));

    assert_full_holds_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && frame_done) |=> full_q);

    assert_idle_needs_high_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_q) |-> $past(bit_tick && rx_in));

    assert_idle_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_q) |-> $past(reg_wr && reg_addr));

    assert_wakeup_blocks_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && rx_wakeup) |=> !idle_q);

endmodule

bind uart_rx_status uart_rx_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_done (frame_done),
    .frame_data (frame_data),
    .data_q     (data_q),
    .full_q     (full_q),
    .idle_q     (idle_q),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .rx_wakeup  (rx_wakeup),
    .bit_tick   (bit_tick),
    .rx_in      (rx_in)
);

// File: tb/sim_uart_rx_status.sv
// Bench: directed scenarios for uart_rx_status, one task per scenario.
module sim_uart_rx_status;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_done = 1'b0;
    logic [DATA_W-1:0] frame_data = '0;
    logic              bit_tick = 1'b0;
    logic              rx_in = 1'b1;
    logic              mode9 = 1'b0;
    logic              rx_wakeup = 1'b0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_addr = 1'b0;
    logic [7:0]        rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_status #(.DATA_W(DATA_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame_data (frame_data),
        .bit_tick   (bit_tick),
        .rx_in      (rx_in),
        .mode9      (mode9),
        .rx_wakeup  (rx_wakeup),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .rd_data    (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Look at a register without issuing an access strobe.
    task automatic peek(input logic addr, output logic [7:0] v);
        reg_addr = addr;
        #1;
        v = rd_data;
        reg_addr = 1'b0;
    endtask

    task automatic status_rd();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b0;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic data_rd();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1;
        @(negedge clk); reg_rd = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic data_wr();
        @(negedge clk); reg_wr = 1'b1; reg_addr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic frame(input logic [7:0] d);
        @(negedge clk); frame_done = 1'b1; frame_data = d;
        @(negedge clk); frame_done = 1'b0;
    endtask

    task automatic bits(input int n, input logic v);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1; rx_in = v;
        end
        @(negedge clk); bit_tick = 1'b0; rx_in = 1'b1;
    endtask

    task automatic clear_idle();
        status_rd();
        data_wr();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(1'b0, v); check("R9 reset status", v, 8'h00);
        peek(1'b1, v); check("R9 reset data", v, 8'h00);
    endtask

    task automatic t_full();
        logic [7:0] v;
        frame(8'hA5);
        peek(1'b0, v); check("R1/R9 status after frame", v, 8'h20);
        peek(1'b1, v); check("R1 data value", v, 8'hA5);
        data_rd();
        peek(1'b0, v); check("R2 read without status read keeps full", v, 8'h20);
        status_rd();
        frame(8'h3C);
        data_rd();
        peek(1'b0, v); check("R3 new frame cancels arming", v, 8'h20);
        peek(1'b1, v); check("R1 second data value", v, 8'h3C);
        status_rd();
        @(negedge clk); reg_rd = 1'b1; reg_addr = 1'b1; frame_done = 1'b1; frame_data = 8'h77;
        @(negedge clk); reg_rd = 1'b0; reg_addr = 1'b0; frame_done = 1'b0;
        peek(1'b0, v); check("R3 frame with clearing read keeps full", v, 8'h20);
        status_rd();
        data_rd();
        peek(1'b0, v); check("R2 full cleared by sequence", v, 8'h00);
    endtask

    task automatic t_idle_basic();
        logic [7:0] v;
        bits(1, 1'b0);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk); rx_in = 1'b1;
        end
        bits(9, 1'b1);
        peek(1'b0, v); check("R4 nine highs, untick cycles ignored", v, 8'h00);
        bits(1, 1'b1);
        peek(1'b0, v); check("R4/R7 tenth high sets idle from reset", v, 8'h10);
        data_wr();
        peek(1'b0, v); check("R6 write without status read keeps idle", v, 8'h10);
        status_rd();
        data_rd();
        peek(1'b0, v); check("R6 data read keeps idle", v, 8'h10);
        status_rd();
        data_wr();
        peek(1'b0, v); check("R6 idle cleared by sequence", v, 8'h00);
        bits(1, 1'b0);
        bits(12, 1'b1);
        peek(1'b0, v); check("R7 no idle before a frame", v, 8'h00);
    endtask

    task automatic t_idle_run();
        logic [7:0] v;
        frame(8'h11);
        status_rd(); data_rd();
        bits(1, 1'b0); bits(5, 1'b1); bits(1, 1'b0); bits(9, 1'b1);
        peek(1'b0, v); check("R5 low restarts run", v, 8'h00);
        bits(1, 1'b1);
        peek(1'b0, v); check("R4 idle after restarted run", v, 8'h10);
        clear_idle();
        frame(8'h22);
        status_rd(); data_rd();
        bits(12, 1'b1);
        peek(1'b0, v); check("R5 saturated run sets nothing", v, 8'h00);
        bits(1, 1'b0); bits(10, 1'b1);
        peek(1'b0, v); check("R7 rearmed by frame", v, 8'h10);
    endtask

    task automatic t_mode9();
        logic [7:0] v;
        clear_idle();
        frame(8'h33);
        status_rd(); data_rd();
        mode9 = 1'b1;
        bits(1, 1'b0); bits(10, 1'b1);
        peek(1'b0, v); check("R4 9-bit mode ten highs", v, 8'h00);
        bits(1, 1'b1);
        peek(1'b0, v); check("R4 9-bit mode eleventh high", v, 8'h10);
        mode9 = 1'b0;
    endtask

    task automatic t_wakeup();
        logic [7:0] v;
        clear_idle();
        frame(8'h44);
        status_rd(); data_rd();
        rx_wakeup = 1'b1;
        bits(1, 1'b0); bits(12, 1'b1);
        peek(1'b0, v); check("R8 wakeup suppresses idle", v, 8'h00);
        rx_wakeup = 1'b0;
        bits(1, 1'b0); bits(10, 1'b1);
        peek(1'b0, v); check("R8 idle after wakeup released", v, 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full();
        t_idle_basic();
        t_idle_run();
        t_mode9();
        t_wakeup();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule